// File: doc/BRIEF.md
# Counter-Rotating Slotted Ring Interconnect

This block moves short coherence messages between the stops of an on-chip ring. Each stop stands for one cache slice paired with the home-node slice that covers the same address range. Two unidirectional rings run in opposite directions. Each ring is a chain of slot registers, one slot per stop, and every occupied slot moves one hop each clock. Many messages can be in flight at once, each holding only its own slot.

A stop offers a message on its injection port with a destination id, a type and a payload. The stop picks the ring with fewer hops to the destination. The stop's own id is attached as the source, and the message enters the next slot only when the ring leaves room. Traffic already on the ring always wins over a new injection. When a message reaches its destination stop, it appears on that stop's ejection port in the cycle it arrives. It carries its source, type, payload, the number of hops it travelled and the ring it came on. If the ejection port is not ready, the message stays on the ring and comes back one full turn later.

Top module: `dual_ring_fabric`

## Requirements
- R1: After reset both rings are empty: no stop's ejection valid is asserted, and every stop's injection ready is asserted.
- R2: A new message goes clockwise when its clockwise distance (destination minus source, modulo the stop count) is at most half the stop count, and otherwise counter-clockwise. A tie at exactly half goes clockwise. Ejection ring flag 0 means clockwise and 1 means counter-clockwise.
- R3: A message accepted at one clock edge without a retry is presented at its destination after a number of edges equal to its hop distance. Its hop field then equals that distance, which is never zero.
- R4: The ejected message carries the injecting stop's id as source, and the type and payload unchanged. It appears only at the stop whose id equals its destination.
- R5: A stop cannot inject into a ring whose incoming slot at that stop holds a message that is passing through. In that cycle, injection toward the other ring is still allowed.
- R6: A message ejected at a stop frees that slot in the same cycle. The stop may inject into that ring in the same cycle.
- R7: A message that arrives while the ejection port is not ready keeps circulating. It is delivered on a later pass, with its hop count grown by the stop count for each missed pass.
- R8: When messages on both rings reach the same stop in one cycle, the clockwise one is ejected. The counter-clockwise one makes a further full turn.
- R9: A message addressed to its own source travels a full clockwise turn and arrives with a hop count equal to the stop count.
- R10: Every accepted message is delivered exactly once. Ring occupancy changes each cycle by exactly the number of accepted injections minus the number of completed ejections.
- R11: A message on a ring that is not ejected at a stop is in the next stop's slot on the same ring one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_valid | input | NSTOPS | Per-stop injection request |
| inj_ready | output | NSTOPS | Per-stop injection accepted this cycle when valid |
| inj_dst | input | NSTOPS*ID_W | Per-stop destination id |
| inj_type | input | NSTOPS*TYPE_W | Per-stop message type |
| inj_data | input | NSTOPS*DATA_W | Per-stop payload |
| ej_valid | output | NSTOPS | Per-stop message arriving for this stop |
| ej_ready | input | NSTOPS | Per-stop ejection acceptance |
| ej_src | output | NSTOPS*ID_W | Source id of the ejected message |
| ej_type | output | NSTOPS*TYPE_W | Type of the ejected message |
| ej_data | output | NSTOPS*DATA_W | Payload of the ejected message |
| ej_hops | output | NSTOPS*HOP_W | Hops travelled, saturating |
| ej_ring | output | NSTOPS | Ring the message arrived on, 0 clockwise |

## Verification
The bench builds the fabric with eight stops, 3-bit ids, a 3-bit type, a 16-bit payload and an 8-bit hop field. An even stop count makes an exact half-ring tie reachable (distance 4). The 16-bit payload can carry a unique tag for every message, so single delivery and latency can be traced per message. The 8-bit hop field leaves room for dozens of retry passes without saturating, so the distance-modulo-stop-count relation can be checked under random back-pressure. Directed cases place two arrivals at one stop, a passing message against a local injection, and an ejection and injection in the same cycle, all at exact cycles.

// File: rtl/ring_pkg.sv
`timescale 1ns/1ps
package ring_pkg;
  typedef enum logic {
    DIR_CW  = 1'b0,
    DIR_CCW = 1'b1
  } ring_dir_e;

  // hops needed going clockwise from src to dst, 0 for a self-addressed message
  function automatic int cw_distance(input int src, input int dst, input int n);
    return (dst - src + n) % n;
  endfunction
endpackage

// File: rtl/ring_route.sv
`timescale 1ns/1ps
module ring_route #(
  parameter int NSTOPS = 8,
  parameter int ID     = 0,
  parameter int ID_W   = 3
) (
  input  logic [ID_W-1:0]     dst,
  output ring_pkg::ring_dir_e dir
);
  import ring_pkg::*;

  always_comb begin
    int d;
    d = cw_distance(ID, int'(dst), NSTOPS);
    // self-addressed messages and exact half-ring ties go clockwise
    if (d == 0 || 2 * d <= NSTOPS) dir = DIR_CW;
    else                           dir = DIR_CCW;
  end
endmodule

// File: rtl/ring_slot.sv
`timescale 1ns/1ps
module ring_slot #(
  parameter int ID_W   = 3,
  parameter int TYPE_W = 3,
  parameter int DATA_W = 16,
  parameter int HOP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_v,
  input  logic [ID_W-1:0]   d_src,
  input  logic [ID_W-1:0]   d_dst,
  input  logic [TYPE_W-1:0] d_type,
  input  logic [DATA_W-1:0] d_data,
  input  logic [HOP_W-1:0]  d_hops,
  output logic              q_v,
  output logic [ID_W-1:0]   q_src,
  output logic [ID_W-1:0]   q_dst,
  output logic [TYPE_W-1:0] q_type,
  output logic [DATA_W-1:0] q_data,
  output logic [HOP_W-1:0]  q_hops
);
  // only occupancy needs a reset; the content is qualified by it
  always_ff @(posedge clk) begin
    if (rst) q_v <= 1'b0;
    else     q_v <= d_v;
  end

  always_ff @(posedge clk) begin
    q_src  <= d_src;
    q_dst  <= d_dst;
    q_type <= d_type;
    q_data <= d_data;
    q_hops <= d_hops;
  end
endmodule

// File: rtl/ring_stop.sv
`timescale 1ns/1ps
module ring_stop #(
  parameter int NSTOPS = 8,
  parameter int ID     = 0,
  parameter int ID_W   = 3,
  parameter int TYPE_W = 3,
  parameter int DATA_W = 16,
  parameter int HOP_W  = 8
) (
  input  logic              cw_v,
  input  logic [ID_W-1:0]   cw_src,
  input  logic [ID_W-1:0]   cw_dst,
  input  logic [TYPE_W-1:0] cw_type,
  input  logic [DATA_W-1:0] cw_data,
  input  logic [HOP_W-1:0]  cw_hops,
  input  logic              ccw_v,
  input  logic [ID_W-1:0]   ccw_src,
  input  logic [ID_W-1:0]   ccw_dst,
  input  logic [TYPE_W-1:0] ccw_type,
  input  logic [DATA_W-1:0] ccw_data,
  input  logic [HOP_W-1:0]  ccw_hops,
  input  logic              inj_valid,
  output logic              inj_ready,
  input  logic [ID_W-1:0]   inj_dst,
  input  logic [TYPE_W-1:0] inj_type,
  input  logic [DATA_W-1:0] inj_data,
  output logic              ej_valid,
  input  logic              ej_ready,
  output logic [ID_W-1:0]   ej_src,
  output logic [TYPE_W-1:0] ej_type,
  output logic [DATA_W-1:0] ej_data,
  output logic [HOP_W-1:0]  ej_hops,
  output logic              ej_ring,
  output logic              cw_nx_v,
  output logic [ID_W-1:0]   cw_nx_src,
  output logic [ID_W-1:0]   cw_nx_dst,
  output logic [TYPE_W-1:0] cw_nx_type,
  output logic [DATA_W-1:0] cw_nx_data,
  output logic [HOP_W-1:0]  cw_nx_hops,
  output logic              ccw_nx_v,
  output logic [ID_W-1:0]   ccw_nx_src,
  output logic [ID_W-1:0]   ccw_nx_dst,
  output logic [TYPE_W-1:0] ccw_nx_type,
  output logic [DATA_W-1:0] ccw_nx_data,
  output logic [HOP_W-1:0]  ccw_nx_hops
);
  import ring_pkg::*;

  localparam logic [ID_W-1:0]  MY_ID   = ID_W'(ID);
  localparam logic [HOP_W-1:0] HOP_ONE = HOP_W'(1);
  localparam logic [HOP_W-1:0] HOP_MAX = {HOP_W{1'b1}};

  function automatic logic [HOP_W-1:0] bump(input logic [HOP_W-1:0] h);
    return (h == HOP_MAX) ? h : h + HOP_ONE;
  endfunction

  ring_dir_e inj_dir;

  ring_route #(
    .NSTOPS(NSTOPS),
    .ID    (ID),
    .ID_W  (ID_W)
  ) u_route (
    .dst(inj_dst),
    .dir(inj_dir)
  );

  logic cw_hit, ccw_hit, take_cw, take_ccw;
  logic cw_free, ccw_free, inj_fire;

  // arrival detection; the clockwise ring owns the single ejection port first
  assign cw_hit   = cw_v  && (cw_dst  == MY_ID);
  assign ccw_hit  = ccw_v && (ccw_dst == MY_ID);
  assign take_cw  = cw_hit && ej_ready;
  assign take_ccw = ccw_hit && !cw_hit && ej_ready;

  // a slot is usable for injection when empty or vacated by ejection now
  assign cw_free   = !cw_v  || take_cw;
  assign ccw_free  = !ccw_v || take_ccw;
  assign inj_ready = (inj_dir == DIR_CW) ? cw_free : ccw_free;
  assign inj_fire  = inj_valid && inj_ready;

  always_comb begin
    ej_valid = cw_hit || ccw_hit;
    if (cw_hit) begin
      ej_src  = cw_src;
      ej_type = cw_type;
      ej_data = cw_data;
      ej_hops = cw_hops;
      ej_ring = 1'b0;
    end else begin
      ej_src  = ccw_src;
      ej_type = ccw_type;
      ej_data = ccw_data;
      ej_hops = ccw_hops;
      ej_ring = 1'b1;
    end
  end

  // clockwise lane: forward passing traffic, otherwise place the injection
  always_comb begin
    cw_nx_v    = 1'b0;
    cw_nx_src  = cw_src;
    cw_nx_dst  = cw_dst;
    cw_nx_type = cw_type;
    cw_nx_data = cw_data;
    cw_nx_hops = bump(cw_hops);
    if (cw_v && !take_cw) begin
      cw_nx_v = 1'b1;
    end else if (inj_fire && inj_dir == DIR_CW) begin
      cw_nx_v    = 1'b1;
      cw_nx_src  = MY_ID;
      cw_nx_dst  = inj_dst;
      cw_nx_type = inj_type;
      cw_nx_data = inj_data;
      cw_nx_hops = HOP_ONE;
    end
  end

  // counter-clockwise lane, same rule
  always_comb begin
    ccw_nx_v    = 1'b0;
    ccw_nx_src  = ccw_src;
    ccw_nx_dst  = ccw_dst;
    ccw_nx_type = ccw_type;
    ccw_nx_data = ccw_data;
    ccw_nx_hops = bump(ccw_hops);
    if (ccw_v && !take_ccw) begin
      ccw_nx_v = 1'b1;
    end else if (inj_fire && inj_dir == DIR_CCW) begin
      ccw_nx_v    = 1'b1;
      ccw_nx_src  = MY_ID;
      ccw_nx_dst  = inj_dst;
      ccw_nx_type = inj_type;
      ccw_nx_data = inj_data;
      ccw_nx_hops = HOP_ONE;
    end
  end
endmodule

// File: rtl/dual_ring_fabric.sv
`timescale 1ns/1ps
module dual_ring_fabric #(
  parameter  int NSTOPS = 8,
  parameter  int TYPE_W = 3,
  parameter  int DATA_W = 16,
  parameter  int HOP_W  = 8,
  localparam int ID_W   = $clog2(NSTOPS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NSTOPS-1:0]          inj_valid,
  output logic [NSTOPS-1:0]          inj_ready,
  input  logic [NSTOPS*ID_W-1:0]     inj_dst,
  input  logic [NSTOPS*TYPE_W-1:0]   inj_type,
  input  logic [NSTOPS*DATA_W-1:0]   inj_data,
  output logic [NSTOPS-1:0]          ej_valid,
  input  logic [NSTOPS-1:0]          ej_ready,
  output logic [NSTOPS*ID_W-1:0]     ej_src,
  output logic [NSTOPS*TYPE_W-1:0]   ej_type,
  output logic [NSTOPS*DATA_W-1:0]   ej_data,
  output logic [NSTOPS*HOP_W-1:0]    ej_hops,
  output logic [NSTOPS-1:0]          ej_ring
);
  // slot contents seen at each stop
  logic [NSTOPS-1:0]             cw_v, ccw_v;
  logic [NSTOPS-1:0][ID_W-1:0]   cw_src, cw_dst, ccw_src, ccw_dst;
  logic [NSTOPS-1:0][TYPE_W-1:0] cw_type, ccw_type;
  logic [NSTOPS-1:0][DATA_W-1:0] cw_data, ccw_data;
  logic [NSTOPS-1:0][HOP_W-1:0]  cw_hops, ccw_hops;

  // values each stop hands to its downstream neighbour on each ring
  logic [NSTOPS-1:0]             cwn_v, ccwn_v;
  logic [NSTOPS-1:0][ID_W-1:0]   cwn_src, cwn_dst, ccwn_src, ccwn_dst;
  logic [NSTOPS-1:0][TYPE_W-1:0] cwn_type, ccwn_type;
  logic [NSTOPS-1:0][DATA_W-1:0] cwn_data, ccwn_data;
  logic [NSTOPS-1:0][HOP_W-1:0]  cwn_hops, ccwn_hops;

  for (genvar g = 0; g < NSTOPS; g++) begin : g_stop
    localparam int PREV = (g + NSTOPS - 1) % NSTOPS;
    localparam int NEXT = (g + 1) % NSTOPS;

    ring_stop #(
      .NSTOPS(NSTOPS), .ID(g), .ID_W(ID_W),
      .TYPE_W(TYPE_W), .DATA_W(DATA_W), .HOP_W(HOP_W)
    ) u_stop (
      .cw_v       (cw_v[g]),
      .cw_src     (cw_src[g]),
      .cw_dst     (cw_dst[g]),
      .cw_type    (cw_type[g]),
      .cw_data    (cw_data[g]),
      .cw_hops    (cw_hops[g]),
      .ccw_v      (ccw_v[g]),
      .ccw_src    (ccw_src[g]),
      .ccw_dst    (ccw_dst[g]),
      .ccw_type   (ccw_type[g]),
      .ccw_data   (ccw_data[g]),
      .ccw_hops   (ccw_hops[g]),
      .inj_valid  (inj_valid[g]),
      .inj_ready  (inj_ready[g]),
      .inj_dst    (inj_dst[g*ID_W +: ID_W]),
      .inj_type   (inj_type[g*TYPE_W +: TYPE_W]),
      .inj_data   (inj_data[g*DATA_W +: DATA_W]),
      .ej_valid   (ej_valid[g]),
      .ej_ready   (ej_ready[g]),
      .ej_src     (ej_src[g*ID_W +: ID_W]),
      .ej_type    (ej_type[g*TYPE_W +: TYPE_W]),
      .ej_data    (ej_data[g*DATA_W +: DATA_W]),
      .ej_hops    (ej_hops[g*HOP_W +: HOP_W]),
      .ej_ring    (ej_ring[g]),
      .cw_nx_v    (cwn_v[g]),
      .cw_nx_src  (cwn_src[g]),
      .cw_nx_dst  (cwn_dst[g]),
      .cw_nx_type (cwn_type[g]),
      .cw_nx_data (cwn_data[g]),
      .cw_nx_hops (cwn_hops[g]),
      .ccw_nx_v   (ccwn_v[g]),
      .ccw_nx_src (ccwn_src[g]),
      .ccw_nx_dst (ccwn_dst[g]),
      .ccw_nx_type(ccwn_type[g]),
      .ccw_nx_data(ccwn_data[g]),
      .ccw_nx_hops(ccwn_hops[g])
    );

    // clockwise slot at stop g is fed by the stop before it
    ring_slot #(
      .ID_W(ID_W), .TYPE_W(TYPE_W), .DATA_W(DATA_W), .HOP_W(HOP_W)
    ) u_cw_slot (
      .clk   (clk),
      .rst   (rst),
      .d_v   (cwn_v[PREV]),
      .d_src (cwn_src[PREV]),
      .d_dst (cwn_dst[PREV]),
      .d_type(cwn_type[PREV]),
      .d_data(cwn_data[PREV]),
      .d_hops(cwn_hops[PREV]),
      .q_v   (cw_v[g]),
      .q_src (cw_src[g]),
      .q_dst (cw_dst[g]),
      .q_type(cw_type[g]),
      .q_data(cw_data[g]),
      .q_hops(cw_hops[g])
    );

    // counter-clockwise slot at stop g is fed by the stop after it
    ring_slot #(
      .ID_W(ID_W), .TYPE_W(TYPE_W), .DATA_W(DATA_W), .HOP_W(HOP_W)
    ) u_ccw_slot (
      .clk   (clk),
      .rst   (rst),
      .d_v   (ccwn_v[NEXT]),
      .d_src (ccwn_src[NEXT]),
      .d_dst (ccwn_dst[NEXT]),
      .d_type(ccwn_type[NEXT]),
      .d_data(ccwn_data[NEXT]),
      .d_hops(ccwn_hops[NEXT]),
      .q_v   (ccw_v[g]),
      .q_src (ccw_src[g]),
      .q_dst (ccw_dst[g]),
      .q_type(ccw_type[g]),
      .q_data(ccw_data[g]),
      .q_hops(ccw_hops[g])
    );
  end
endmodule

// File: rtl/ring_fabric_checker.sv
`timescale 1ns/1ps
module ring_fabric_checker #(
  parameter int NSTOPS = 8,
  parameter int ID_W   = 3,
  parameter int HOP_W  = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NSTOPS-1:0]        inj_valid,
  input logic [NSTOPS-1:0]        inj_ready,
  input logic [NSTOPS-1:0]        ej_valid,
  input logic [NSTOPS-1:0]        ej_ready,
  input logic [NSTOPS*ID_W-1:0]   ej_src,
  input logic [NSTOPS*HOP_W-1:0]  ej_hops,
  input logic [NSTOPS-1:0]        ej_ring,
  input logic [NSTOPS-1:0]        cw_v,
  input logic [NSTOPS-1:0]        ccw_v,
  input logic [NSTOPS-1:0][ID_W-1:0] cw_dst,
  input logic [NSTOPS-1:0][ID_W-1:0] ccw_dst
);
  int occ, n_inj, n_ej;

  always_comb begin
    occ   = $countones(cw_v) + $countones(ccw_v);
    n_inj = $countones(inj_valid & inj_ready);
    n_ej  = $countones(ej_valid & ej_ready);
  end

  AST_OCCUPANCY_BALANCE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> occ == $past(occ) + $past(n_inj) - $past(n_ej)); // R10

  for (genvar k = 0; k < NSTOPS; k++) begin : g_chk
    localparam int NEXT = (k + 1) % NSTOPS;
    localparam int PREV = (k + NSTOPS - 1) % NSTOPS;
    localparam logic [ID_W-1:0] KID = ID_W'(k);

    AST_CW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      cw_v[k] && !(cw_dst[k] == KID && ej_ready[k]) |=> cw_v[NEXT]); // R11

    AST_CCW_YIELDS: assert property (@(posedge clk) disable iff (rst)
      ccw_v[k] && ccw_dst[k] == KID && cw_v[k] && cw_dst[k] == KID
      |=> ccw_v[PREV]); // R8

    AST_HOPS_NONZERO: assert property (@(posedge clk) disable iff (rst)
      ej_valid[k] |-> ej_hops[k*HOP_W +: HOP_W] != '0); // R3

    AST_SELF_FULL_TURN: assert property (@(posedge clk) disable iff (rst)
      ej_valid[k] && ej_src[k*ID_W +: ID_W] == KID
      |-> ej_ring[k] == 1'b0 && int'(ej_hops[k*HOP_W +: HOP_W]) >= NSTOPS); // R9
  end
endmodule

bind dual_ring_fabric ring_fabric_checker #(
  .NSTOPS(NSTOPS), .ID_W(ID_W), .HOP_W(HOP_W)
) i_ring_chk (.*);

// File: tb/test_dual_ring_fabric.sv
`timescale 1ns/1ps
module test_dual_ring_fabric;
  localparam int N = 8, IDW = 3, TW = 3, DW = 16, HW = 8, MAXM = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [N-1:0]     inj_valid, inj_ready, ej_valid, ej_ready, ej_ring;
  logic [N*IDW-1:0] inj_dst, ej_src;
  logic [N*TW-1:0]  inj_type, ej_type;
  logic [N*DW-1:0]  inj_data, ej_data;
  logic [N*HW-1:0]  ej_hops;

  dual_ring_fabric #(.NSTOPS(N), .TYPE_W(TW), .DATA_W(DW), .HOP_W(HW)) i_dual_ring_fabric (
    .clk(clk), .rst(rst),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_dst(inj_dst),
    .inj_type(inj_type), .inj_data(inj_data),
    .ej_valid(ej_valid), .ej_ready(ej_ready), .ej_src(ej_src),
    .ej_type(ej_type), .ej_data(ej_data), .ej_hops(ej_hops), .ej_ring(ej_ring)
  );

  int checks = 0, fails = 0, cyc = 0, ntag = 0;
  int m_src[MAXM], m_dst[MAXM], m_type[MAXM], m_acc[MAXM];
  int d_cnt[MAXM], d_hops[MAXM], d_dir[MAXM];
  logic [N-1:0] took;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cw_d(input int s, input int d);
    int c;
    c = (d - s + N) % N;
    return (c == 0) ? N : c;
  endfunction
  function automatic int exp_dir(input int s, input int d);
    int c;
    c = cw_d(s, d);
    return (c == N || 2 * c <= N) ? 0 : 1;
  endfunction
  function automatic int exp_hops(input int s, input int d);
    int c;
    c = cw_d(s, d);
    if (c == N) return N;
    return (exp_dir(s, d) == 0) ? c : N - c;
  endfunction

  task automatic set_inj(input int k, input bit v, input int dst, input int typ, input int tag);
    inj_valid[k] = v;
    inj_dst[k*IDW +: IDW] = IDW'(dst);
    inj_type[k*TW +: TW]  = TW'(typ);
    inj_data[k*DW +: DW]  = DW'(tag);
  endtask

  task automatic monitor();
    for (int k = 0; k < N; k++) begin
      took[k] = 1'b0;
      if (inj_valid[k] && inj_ready[k]) begin
        int t;
        t = int'(inj_data[k*DW +: DW]);
        m_src[t] = k; m_dst[t] = int'(inj_dst[k*IDW +: IDW]);
        m_type[t] = int'(inj_type[k*TW +: TW]); m_acc[t] = cyc;
        took[k] = 1'b1;
      end
      if (ej_valid[k] && ej_ready[k]) begin
        int t, h, s;
        t = int'(ej_data[k*DW +: DW]);
        h = int'(ej_hops[k*HW +: HW]);
        s = int'(ej_src[k*IDW +: IDW]);
        if (t >= MAXM || m_acc[t] < 0) begin
          chk(1'b0, "R4", "unknown tag ejected", t, -1);
        end else begin
          d_cnt[t]++; d_hops[t] = h; d_dir[t] = int'(ej_ring[k]);
          chk(k == m_dst[t], "R4", "eject stop", k, m_dst[t]);
          chk(s == m_src[t] && int'(ej_type[k*TW +: TW]) == m_type[t], "R4", "source id", s, m_src[t]);
          chk(int'(ej_ring[k]) == exp_dir(m_src[t], m_dst[t]), "R2", "ring", int'(ej_ring[k]),
              exp_dir(m_src[t], m_dst[t]));
          if (h != 255) begin
            chk(cyc - m_acc[t] == h, "R3", "latency vs hops", cyc - m_acc[t], h);
            chk((h - exp_hops(m_src[t], m_dst[t])) % N == 0 && h >= exp_hops(m_src[t], m_dst[t]),
                "R7", "hops modulo ring", h, exp_hops(m_src[t], m_dst[t]));
          end
        end
      end
    end
  endtask

  task automatic tick();
    #1;
    monitor();
    @(negedge clk);
    cyc++;
  endtask

  task automatic settle();
    #0.4;
  endtask

  function automatic int new_tag();
    ntag++;
    return ntag - 1;
  endfunction

  task automatic wait_done(input int t);
    for (int i = 0; i < 60 && d_cnt[t] == 0; i++) tick();
  endtask

  task automatic send_one(input int s, input int d, input int typ, output int t);
    t = new_tag();
    set_inj(s, 1'b1, d, typ, t);
    tick();
    set_inj(s, 1'b0, 0, 0, 0);
    wait_done(t);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t, ta, tb;
    logic [N-1:0] pend;
    void'($urandom(32'd20171));
    for (int i = 0; i < MAXM; i++) begin
      m_acc[i] = -1; d_cnt[i] = 0;
    end
    inj_valid = '0; inj_dst = '0; inj_type = '0; inj_data = '0; ej_ready = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: empty rings after reset
    settle();
    chk(ej_valid == '0, "R1", "ej_valid after reset", int'(ej_valid), 0);
    chk(inj_ready == '1, "R1", "inj_ready after reset", int'(inj_ready), 255);
    tick();

    // R2 R3 R4: single messages from stop 1 to each other stop, tie at distance 4
    for (int d = 0; d < N; d++) begin
      if (d == 1) continue;
      send_one(1, d, d % 8, t);
      chk(d_cnt[t] == 1, "R10", "delivered once", d_cnt[t], 1);
      chk(d_hops[t] == exp_hops(1, d), "R3", "hops equal short distance", d_hops[t], exp_hops(1, d));
      chk(d_dir[t] == exp_dir(1, d), "R2", "shorter ring, tie clockwise", d_dir[t], exp_dir(1, d));
    end

    // R9: self-addressed message
    send_one(3, 3, 2, t);
    chk(d_hops[t] == N && d_dir[t] == 0, "R9", "loopback full turn hops", d_hops[t], N);

    // R5: passing traffic blocks local injection on that ring only
    ta = new_tag();
    set_inj(0, 1'b1, 3, 1, ta);
    tick();
    set_inj(0, 1'b0, 0, 0, 0);
    set_inj(1, 1'b0, 2, 0, 0);
    settle();
    chk(inj_ready[1] == 1'b0, "R5", "cw inject blocked by passing msg", int'(inj_ready[1]), 0);
    set_inj(1, 1'b0, 7, 0, 0);
    settle();
    chk(inj_ready[1] == 1'b1, "R5", "ccw inject still allowed", int'(inj_ready[1]), 1);
    set_inj(1, 1'b0, 0, 0, 0);
    tick();
    wait_done(ta);
    chk(d_hops[ta] == 3, "R5", "passing msg undisturbed", d_hops[ta], 3);

    // R6: ejection and injection at the same stop in one cycle
    ta = new_tag();
    set_inj(0, 1'b1, 2, 3, ta);
    tick();
    set_inj(0, 1'b0, 0, 0, 0);
    tick();
    tb = new_tag();
    set_inj(2, 1'b1, 3, 4, tb);
    settle();
    chk(ej_valid[2] == 1'b1, "R6", "arrival visible", int'(ej_valid[2]), 1);
    chk(inj_ready[2] == 1'b1, "R6", "slot freed for injection", int'(inj_ready[2]), 1);
    tick();
    set_inj(2, 1'b0, 0, 0, 0);
    wait_done(tb);
    chk(d_cnt[ta] == 1 && d_hops[ta] == 2, "R6", "ejected msg hops", d_hops[ta], 2);
    chk(d_cnt[tb] == 1 && d_hops[tb] == 1, "R6", "same-cycle injection hops", d_hops[tb], 1);

    // R7: ejection not ready on first pass
    ej_ready[2] = 1'b0;
    ta = new_tag();
    set_inj(0, 1'b1, 2, 5, ta);
    tick();
    set_inj(0, 1'b0, 0, 0, 0);
    tick();
    set_inj(2, 1'b0, 3, 0, 0);
    settle();
    chk(ej_valid[2] == 1'b1, "R7", "arrival while not ready", int'(ej_valid[2]), 1);
    chk(inj_ready[2] == 1'b0, "R7", "retained msg keeps slot", int'(inj_ready[2]), 0);
    set_inj(2, 1'b0, 0, 0, 0);
    tick();
    repeat (3) tick();
    ej_ready[2] = 1'b1;
    wait_done(ta);
    chk(d_cnt[ta] == 1 && d_hops[ta] == 2 + N, "R7", "hops after one retry", d_hops[ta], 2 + N);

    // R8: both rings arrive at stop 2 together
    ta = new_tag();
    tb = new_tag();
    set_inj(0, 1'b1, 2, 6, ta);
    set_inj(4, 1'b1, 2, 7, tb);
    tick();
    set_inj(0, 1'b0, 0, 0, 0);
    set_inj(4, 1'b0, 0, 0, 0);
    wait_done(tb);
    chk(d_hops[ta] == 2 && d_dir[ta] == 0, "R8", "cw arrival ejected first", d_hops[ta], 2);
    chk(d_hops[tb] == 2 + N && d_dir[tb] == 1, "R8", "ccw arrival makes a turn", d_hops[tb], 2 + N);

    // R10: random traffic with back-pressure
    pend = '0;
    for (int c = 0; c < 1500; c++) begin
      for (int k = 0; k < N; k++) begin
        if (!pend[k] && ntag < MAXM - 1 && ($urandom % 4) == 0) begin
          pend[k] = 1'b1;
          set_inj(k, 1'b1, int'($urandom % N), int'($urandom % 8), new_tag());
        end
        ej_ready[k] = (($urandom % 8) != 0);
      end
      tick();
      for (int k = 0; k < N; k++) begin
        if (took[k]) begin
          pend[k] = 1'b0;
          set_inj(k, 1'b0, 0, 0, 0);
        end
      end
    end
    inj_valid = '0;
    ej_ready = '1;
    repeat (80) tick();
    for (int i = 0; i < ntag; i++) begin
      if (m_acc[i] >= 0) chk(d_cnt[i] == 1, "R10", "exactly-once delivery", d_cnt[i], 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule